// File: doc/BRIEF.md
# Ramp-and-Match Trim Calibration Sequencer

This block is the digital side of a two-point converter calibration loop. A host starts a cycle and picks the correction point to work on: the zero-level (offset) trim or the full-scale (gain) trim. The sequencer steers the input multiplexer to the matching reference, then steps a trim-DAC code upward from zero, one count per conversion. For each step it starts the ADC, waits for the data-valid strobe, and tests the result for equality with the target code held for that point.

On equality it emits a one-cycle active-low stop strobe, freezes the code and finishes. The code stays on that point's trim output until a later cycle for the same point replaces it. If the code reaches its top value without a match, the cycle ends with a fail flag and the code held before the cycle comes back. A target equal to all zeros or all ones would make the loop hunt against a range limit, so such a target is refused with an error flag and no conversion takes place. Between a result and the next conversion the block waits a host-set number of settling cycles, so the analog trim can settle.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `fail_o`, `tgt_err_o` and `conv_start_o` are 0, `stop_n_o` is 1, and both trim outputs are 0.
- R2: A start with `mode_i`=0 calibrates offset and drives `mux_sel_o` to `OFF_CH` (default 0). A start with `mode_i`=1 calibrates gain and drives `GAIN_CH` (default 1). The select holds steady while `busy_o` is high.
- R3: In an accepted cycle the selected trim output is 0 at the first conversion and rises by exactly 1 from one conversion to the next.
- R4: `conv_start_o` is a one-cycle pulse given only while busy. A conversion is never started before the previous result has arrived. After each non-final result the block waits the settling delay, and raising `settle_i` by N lengthens the spacing between conversions by exactly N cycles.
- R5: When `adc_data_i` equals the selected target while `adc_valid_i` is high, `stop_n_o` goes low for one cycle and the ramp stops. The selected trim output keeps the matching code. The other trim output does not change during the cycle.
- R6: A trim output keeps its value outside cycles for its own point, including through cycles for the other point.
- R7: If the code is at all ones and the result still does not match, `fail_o` is set and the trim code held before the cycle is restored. `fail_o` and `tgt_err_o` are never both high.
- R8: A start whose selected target is all zeros or all ones produces no conversion. It sets `tgt_err_o` and pulses `done_o` in the next cycle, and both trims keep their values. The next accepted start clears both `tgt_err_o` and `fail_o`.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle ends. A start while busy is ignored.
- R10: `done_o` is high for exactly one cycle per started cycle, and never while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a calibration cycle |
| mode_i | input | 1 | 0 = offset point, 1 = gain point |
| settle_i | input | SETTLE_W | Settling cycles between a result and the next conversion |
| tgt_off_i | input | CODE_W | Target ADC code for the offset point |
| tgt_gain_i | input | CODE_W | Target ADC code for the gain point |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle end-of-cycle strobe |
| fail_o | output | 1 | Last cycle hit terminal count with no match |
| tgt_err_o | output | 1 | Last start was refused because its target was an endpoint code |
| mux_sel_o | output | MUX_W | Reference multiplexer channel select |
| conv_start_o | output | 1 | ADC convert-start pulse |
| adc_valid_i | input | 1 | ADC result valid |
| adc_data_i | input | CODE_W | ADC result |
| stop_n_o | output | 1 | Active-low one-cycle match strobe |
| trim_off_o | output | TRIM_W | Offset trim-DAC code |
| trim_gain_o | output | TRIM_W | Gain trim-DAC code |

## Verification
Every cycle, the assertions check the pulse shapes of the convert, stop and done strobes, and that a conversion is only started while busy. They also check the steady mux select during a cycle, the +1-or-hold movement of the active trim, the untouched other trim, the held trims while idle, and that fail and error are never both raised. Only the bench scenarios can show the end results. These are that the ramp ends at the code the model ADC needs for the target, that a missed search restores the earlier code, and that endpoint targets cause no conversion at all. They also show that a mid-cycle start changes nothing, and that the spacing between conversions grows by exactly the settling count.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_WAIT   = 2'd3
    } cal_state_e;

    localparam logic PT_OFFSET = 1'b0;
    localparam logic PT_GAIN   = 1'b1;
    localparam int   NUM_POINTS = 2;
endpackage

// File: rtl/cal_target_check.sv
module cal_target_check
    import trim_cal_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [NUM_POINTS-1:0][CODE_W-1:0] tgt_i,
    input  logic                              sel_i,
    output logic [CODE_W-1:0]                 sel_tgt_o,
    output logic [NUM_POINTS-1:0]             at_end_o
);
    localparam logic [CODE_W-1:0] CODE_LO = '0;
    localparam logic [CODE_W-1:0] CODE_HI = '1;

    for (genvar g = 0; g < NUM_POINTS; g++) begin : g_pt
        assign at_end_o[g] = (tgt_i[g] == CODE_LO) || (tgt_i[g] == CODE_HI);
    end

    assign sel_tgt_o = tgt_i[sel_i];
endmodule

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);
endmodule

// File: rtl/cal_trim_bank.sv
module cal_trim_bank
    import trim_cal_pkg::*;
#(
    parameter int TRIM_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel_i,
    input  logic                              clear_i,
    input  logic                              step_i,
    input  logic                              restore_i,
    output logic [NUM_POINTS-1:0][TRIM_W-1:0] code_o,
    output logic                              at_max_o
);
    localparam logic [TRIM_W-1:0] CODE_TOP = '1;

    typedef struct packed {
        logic [TRIM_W-1:0] code;
        logic [TRIM_W-1:0] saved;
    } lane_t;

    for (genvar g = 0; g < NUM_POINTS; g++) begin : g_lane
        lane_t lane_d, lane_q;
        logic  hit;

        assign hit = (sel_i == 1'(g));

        always_comb begin
            lane_d = lane_q;
            if (hit) begin
                if (clear_i) begin
                    lane_d.saved = lane_q.code;
                    lane_d.code  = '0;
                end else if (restore_i) begin
                    lane_d.code  = lane_q.saved;
                end else if (step_i) begin
                    lane_d.code  = lane_q.code + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign code_o[g] = lane_q.code;
    end

    assign at_max_o = (code_o[sel_i] == CODE_TOP);
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
    import trim_cal_pkg::*;
#(
    parameter int                CODE_W   = 12,
    parameter int                TRIM_W   = 6,
    parameter int                SETTLE_W = 8,
    parameter int                MUX_W    = 2,
    parameter logic [MUX_W-1:0]  OFF_CH   = 2'd0,
    parameter logic [MUX_W-1:0]  GAIN_CH  = 2'd1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [CODE_W-1:0]   tgt_off_i,
    input  logic [CODE_W-1:0]   tgt_gain_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output logic                tgt_err_o,
    output logic [MUX_W-1:0]    mux_sel_o,
    output logic                conv_start_o,
    input  logic                adc_valid_i,
    input  logic [CODE_W-1:0]   adc_data_i,
    output logic                stop_n_o,
    output logic [TRIM_W-1:0]   trim_off_o,
    output logic [TRIM_W-1:0]   trim_gain_o
);
    typedef struct packed {
        cal_state_e       state;
        logic             mode;
        logic             busy;
        logic             done;
        logic             fail;
        logic             err;
        logic             stop_n;
        logic [MUX_W-1:0] mux;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_POINTS-1:0][CODE_W-1:0] tgt_vec;
    logic [NUM_POINTS-1:0][TRIM_W-1:0] trim_vec;
    logic [NUM_POINTS-1:0]             tgt_at_end;
    logic [CODE_W-1:0]                 tgt_sel;
    logic                              pt_sel;
    logic                              tmr_load, tmr_zero;
    logic                              bank_clear, bank_step, bank_restore, bank_at_max;

    assign tgt_vec[PT_OFFSET] = tgt_off_i;
    assign tgt_vec[PT_GAIN]   = tgt_gain_i;

    // While idle the incoming request picks the point; afterwards the stored one.
    assign pt_sel = (ctrl_q.state == ST_IDLE) ? mode_i : ctrl_q.mode;

    cal_target_check #(.CODE_W(CODE_W)) u_tgt (
        .tgt_i     (tgt_vec),
        .sel_i     (pt_sel),
        .sel_tgt_o (tgt_sel),
        .at_end_o  (tgt_at_end)
    );

    cal_settle_timer #(.CNT_W(SETTLE_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (settle_i),
        .zero_o     (tmr_zero)
    );

    cal_trim_bank #(.TRIM_W(TRIM_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (pt_sel),
        .clear_i   (bank_clear),
        .step_i    (bank_step),
        .restore_i (bank_restore),
        .code_o    (trim_vec),
        .at_max_o  (bank_at_max)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.done  = 1'b0;
        ctrl_d.stop_n = 1'b1;
        tmr_load     = 1'b0;
        bank_clear   = 1'b0;
        bank_step    = 1'b0;
        bank_restore = 1'b0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.mode = mode_i;
                    ctrl_d.fail = 1'b0;
                    if (tgt_at_end[mode_i]) begin
                        ctrl_d.err  = 1'b1;
                        ctrl_d.done = 1'b1;
                    end else begin
                        ctrl_d.err   = 1'b0;
                        ctrl_d.busy  = 1'b1;
                        ctrl_d.mux   = mode_i ? GAIN_CH : OFF_CH;
                        ctrl_d.state = ST_SETTLE;
                        bank_clear   = 1'b1;
                        tmr_load     = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    ctrl_d.state = ST_CONV;
                end
            end
            ST_CONV: begin
                ctrl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (adc_valid_i) begin
                    if (adc_data_i == tgt_sel) begin
                        ctrl_d.stop_n = 1'b0;
                        ctrl_d.done   = 1'b1;
                        ctrl_d.busy   = 1'b0;
                        ctrl_d.state  = ST_IDLE;
                    end else if (bank_at_max) begin
                        bank_restore  = 1'b1;
                        ctrl_d.fail   = 1'b1;
                        ctrl_d.done   = 1'b1;
                        ctrl_d.busy   = 1'b0;
                        ctrl_d.state  = ST_IDLE;
                    end else begin
                        bank_step     = 1'b1;
                        tmr_load      = 1'b1;
                        ctrl_d.state  = ST_SETTLE;
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            ctrl_q.state  <= ST_IDLE;
            ctrl_q.stop_n <= 1'b1;
            ctrl_q.mux    <= OFF_CH;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o       = ctrl_q.busy;
    assign done_o       = ctrl_q.done;
    assign fail_o       = ctrl_q.fail;
    assign tgt_err_o    = ctrl_q.err;
    assign stop_n_o     = ctrl_q.stop_n;
    assign mux_sel_o    = ctrl_q.mux;
    assign conv_start_o = (ctrl_q.state == ST_CONV);
    assign trim_off_o   = trim_vec[PT_OFFSET];
    assign trim_gain_o  = trim_vec[PT_GAIN];

    // R2: reference routing does not move inside a cycle
    assert_mux_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

    // R3: active trim either holds or advances by one while busy
    assert_ramp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && ctrl_q.mode == PT_OFFSET) |->
        (trim_off_o == $past(trim_off_o) || trim_off_o == $past(trim_off_o) + 1'b1));

    assert_ramp_step_gain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && ctrl_q.mode == PT_GAIN) |->
        (trim_gain_o == $past(trim_gain_o) || trim_gain_o == $past(trim_gain_o) + 1'b1));

    // R4: convert-start is a single-cycle pulse issued only inside a cycle
    assert_conv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_conv_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> busy_o);

    // R5: stop strobe is one cycle wide; the other point's trim is untouched
    assert_stop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n_o |=> stop_n_o);

    assert_other_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctrl_q.mode == PT_GAIN) |-> $stable(trim_off_o));

    assert_other_hold_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctrl_q.mode == PT_OFFSET) |-> $stable(trim_gain_o));

    // R6: trims hold while no cycle runs
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> ($stable(trim_off_o) && $stable(trim_gain_o)));

    // R7: fail and endpoint error are exclusive
    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_o && tgt_err_o));

    // R10: done is a single-cycle strobe outside busy
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/trim_cal_seq_test.sv
module trim_cal_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W = 12;
    localparam int TRIM_W = 6;
    localparam int SETTLE_W = 8;
    localparam int OFF_BASE = 100;
    localparam int GAIN_BASE = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic [SETTLE_W-1:0] settle_i = '0;
    logic [CODE_W-1:0] tgt_off_i = 12'd120;
    logic [CODE_W-1:0] tgt_gain_i = 12'd2026;
    logic busy_o, done_o, fail_o, tgt_err_o, conv_start_o, stop_n_o;
    logic [1:0] mux_sel_o;
    logic adc_valid_i = 1'b0;
    logic [CODE_W-1:0] adc_data_i = '0;
    logic [TRIM_W-1:0] trim_off_o, trim_gain_o;

    int checks = 0;
    int fails = 0;
    logic bench_mode = 1'b0;

    int cyc = 0, conv_cnt = 0, done_cnt = 0, stop_cnt = 0;
    int step_err = 0, mux_err = 0, done_busy = 0;
    int exp_step = 0, last_conv = 0, last_gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_cal_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .settle_i(settle_i), .tgt_off_i(tgt_off_i), .tgt_gain_i(tgt_gain_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .tgt_err_o(tgt_err_o),
        .mux_sel_o(mux_sel_o), .conv_start_o(conv_start_o),
        .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i), .stop_n_o(stop_n_o),
        .trim_off_o(trim_off_o), .trim_gain_o(trim_gain_o)
    );

    // ADC model: result two cycles after a convert pulse, linear in the trim code
    initial begin
        int cd;
        cd = 0;
        forever begin
            @(negedge clk);
            adc_valid_i = 1'b0;
            if (cd != 0) begin
                cd--;
                if (cd == 0) begin
                    adc_valid_i = 1'b1;
                    adc_data_i = bench_mode ? CODE_W'(GAIN_BASE + 2 * int'(trim_gain_o))
                                            : CODE_W'(OFF_BASE + int'(trim_off_o));
                end
            end
            if (conv_start_o) cd = 2;
        end
    end

    // Observer: counts strobes, tracks ramp order and conversion spacing
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!busy_o) exp_step = 0;
            if (done_o) done_cnt++;
            if (done_o && busy_o) done_busy++;
            if (!stop_n_o) stop_cnt++;
            if (busy_o && mux_sel_o != (bench_mode ? 2'd1 : 2'd0)) mux_err++;
            if (conv_start_o) begin
                conv_cnt++;
                if (int'(bench_mode ? trim_gain_o : trim_off_o) != exp_step) step_err++;
                exp_step++;
                last_gap = cyc - last_conv;
                last_conv = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Start one cycle and wait for its end; returns cycles waited
    task automatic run_cycle(input logic m, output int waited);
        @(negedge clk);
        mode_i = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done after reset", int'({busy_o, done_o}), 0);
        chk(fail_o == 1'b0 && tgt_err_o == 1'b0, "R1", "fail/err after reset", int'({fail_o, tgt_err_o}), 0);
        chk(conv_start_o == 1'b0 && stop_n_o == 1'b1, "R1", "conv/stop_n after reset", int'({conv_start_o, stop_n_o}), 1);
        chk(trim_off_o == '0 && trim_gain_o == '0, "R1", "trims after reset", int'({trim_off_o, trim_gain_o}), 0);
    endtask

    task automatic t_offset_match();
        int w, c0, s0, d0;
        tgt_off_i = 12'(OFF_BASE + 20);
        bench_mode = 1'b0;
        c0 = conv_cnt; s0 = stop_cnt; d0 = done_cnt;
        run_cycle(1'b0, w);
        chk(w < 5000, "R5", "offset cycle finished", w, 0);
        chk(trim_off_o == 6'd20, "R5", "offset trim at match", int'(trim_off_o), 20);
        chk(trim_gain_o == 6'd0, "R5", "gain trim untouched", int'(trim_gain_o), 0);
        chk(conv_cnt - c0 == 21, "R3", "conversions for code 20", conv_cnt - c0, 21);
        chk(stop_cnt - s0 == 1, "R5", "one stop strobe", stop_cnt - s0, 1);
        chk(done_cnt - d0 == 1, "R10", "one done strobe", done_cnt - d0, 1);
        chk(fail_o == 1'b0 && tgt_err_o == 1'b0, "R7", "no fail on match", int'({fail_o, tgt_err_o}), 0);
    endtask

    task automatic t_gain_match();
        int w, c0;
        tgt_gain_i = 12'(GAIN_BASE + 26);
        bench_mode = 1'b1;
        c0 = conv_cnt;
        run_cycle(1'b1, w);
        chk(trim_gain_o == 6'd13, "R5", "gain trim at match", int'(trim_gain_o), 13);
        chk(trim_off_o == 6'd20, "R6", "offset trim kept across gain cycle", int'(trim_off_o), 20);
        chk(conv_cnt - c0 == 14, "R3", "conversions for code 13", conv_cnt - c0, 14);
    endtask

    task automatic t_fail();
        int w, c0, s0;
        tgt_gain_i = 12'(GAIN_BASE + 1);
        bench_mode = 1'b1;
        c0 = conv_cnt; s0 = stop_cnt;
        run_cycle(1'b1, w);
        chk(fail_o == 1'b1, "R7", "fail flag on exhausted ramp", int'(fail_o), 1);
        chk(trim_gain_o == 6'd13, "R7", "gain trim restored", int'(trim_gain_o), 13);
        chk(conv_cnt - c0 == 64, "R7", "full ramp conversions", conv_cnt - c0, 64);
        chk(stop_cnt == s0, "R7", "no stop strobe on fail", stop_cnt - s0, 0);
        chk(tgt_err_o == 1'b0, "R7", "error not raised with fail", int'(tgt_err_o), 0);
    endtask

    task automatic t_endpoint(input logic [CODE_W-1:0] bad);
        int w, c0, d0;
        tgt_off_i = bad;
        c0 = conv_cnt; d0 = done_cnt;
        run_cycle(1'b0, w);
        chk(w == 0, "R8", "done in cycle after refused start", w, 0);
        chk(tgt_err_o == 1'b1, "R8", "endpoint error flag", int'(tgt_err_o), 1);
        chk(fail_o == 1'b0, "R8", "fail cleared by new start", int'(fail_o), 0);
        repeat (4) @(negedge clk);
        chk(conv_cnt == c0, "R8", "no conversion for endpoint", conv_cnt - c0, 0);
        chk(done_cnt - d0 == 1, "R10", "single done for refused start", done_cnt - d0, 1);
        chk(trim_off_o == 6'd20 && trim_gain_o == 6'd13, "R8", "trims kept on refusal",
            int'({trim_off_o, trim_gain_o}), int'({6'd20, 6'd13}));
    endtask

    task automatic t_busy_ignore();
        int d0, n;
        tgt_off_i = 12'(OFF_BASE + 30);
        bench_mode = 1'b0;
        d0 = done_cnt;
        @(negedge clk);
        mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after accepted start", int'(busy_o), 1);
        chk(tgt_err_o == 1'b0, "R8", "error cleared by accepted start", int'(tgt_err_o), 0);
        repeat (6) @(negedge clk);
        mode_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (10) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9", "start during busy ignored", done_cnt - d0, 1);
        chk(trim_off_o == 6'd30, "R9", "offset trim of accepted cycle", int'(trim_off_o), 30);
        chk(trim_gain_o == 6'd13, "R9", "gain trim unaffected", int'(trim_gain_o), 13);
        chk(busy_o == 1'b0, "R9", "busy released", int'(busy_o), 0);
    endtask

    task automatic t_settle();
        int w, g0, g5;
        tgt_off_i = 12'(OFF_BASE + 4);
        bench_mode = 1'b0;
        settle_i = 8'd0;
        run_cycle(1'b0, w);
        g0 = last_gap;
        settle_i = 8'd5;
        run_cycle(1'b0, w);
        g5 = last_gap;
        chk(g5 - g0 == 5, "R4", "spacing grows by settle count", g5 - g0, 5);
        chk(g0 >= 3, "R4", "conversion waits for result", g0, 3);
        chk(trim_off_o == 6'd4, "R5", "match with settling", int'(trim_off_o), 4);
        settle_i = 8'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset_match();
        t_gain_match();
        t_fail();
        t_endpoint(12'd0);
        t_endpoint(12'hFFF);
        t_busy_ignore();
        t_settle();
        chk(step_err == 0, "R3", "ramp order at each conversion", step_err, 0);
        chk(mux_err == 0, "R2", "mux select per point", mux_err, 0);
        chk(done_busy == 0, "R10", "done never with busy", done_busy, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule